// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulse Generator

This block is a synchronous one-shot timer. It drives `pulse_q` high for a programmed number of clock cycles, and `pulse_qn` always carries the inverse. Three conditions start a pulse. The first is a rising edge on the active-high gate `arm_b` while the active-low gate `arm_an` is low. The second is a falling edge on `arm_an` while `arm_b` is high. The third is the release of the active-low `kill_n` input while `arm_an` is low and `arm_b` is high.

The pulse length is a cycle count read from `len_cycles` at the clock edge that takes a trigger. A later trigger during a pulse reloads the count, so the high time is stretched to one full length counted from the newest trigger. Pulling `kill_n` low forces the output low in the same cycle, clears the count and blocks every trigger for as long as it stays low. All inputs are assumed to be synchronous to `clk` already.

Edges are found by comparing each input with its value at the previous clock edge. While reset is held, the edge registers follow the inputs, so input levels present at reset release produce no trigger.

Top module: `oneshot_gen`

## Requirements
- R1: A rising edge on `arm_b` sampled while `arm_an` is 0 and `kill_n` is 1 starts a pulse: `pulse_q` is 1 from the next clock edge onward.
- R2: A falling edge on `arm_an` sampled while `arm_b` is 1 and `kill_n` is 1 starts a pulse at the next clock edge.
- R3: A rising edge on `kill_n` sampled while `arm_an` is 0 and `arm_b` is 1 starts a pulse at the next clock edge.
- R4: While `kill_n` is 0, `pulse_q` is 0 in the same cycle, a running pulse is cancelled, and triggers are ignored. This includes a trigger in the cycle where `kill_n` falls.
- R5: A qualifying trigger during a pulse reloads the count, so the high time equals the time to the retrigger plus `len_cycles`.
- R6: With `arm_an` held at 1, or `arm_b` held at 0 and `arm_an` never falling, the edges that occur produce no pulse.
- R7: After a trigger `pulse_q` stays high for exactly `len_cycles` clock cycles. The length is taken at the trigger edge, and later changes to `len_cycles` do not alter the running pulse.
- R8: A trigger taken while `len_cycles` is 0 and the block is idle produces no pulse.
- R9: `pulse_qn` is the inverse of `pulse_q` at all times.
- R10: Synchronous reset clears the count and forces `pulse_q` to 0. Input levels held steady across reset release produce no trigger.
- R11: A `kill_n` release in the same cycle as an `arm_b` rise produces a single pulse of `len_cycles`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_an | input | 1 | Active-low gated trigger; its falling edge fires |
| arm_b | input | 1 | Active-high gated trigger; its rising edge fires |
| kill_n | input | 1 | Active-low clear; its release may fire |
| len_cycles | input | CNT_W | Pulse length in clock cycles, taken at each trigger |
| pulse_q | output | 1 | One-shot output |
| pulse_qn | output | 1 | Inverse of pulse_q |

## Verification
Each of the three trigger paths is fired separately, with the other inputs parked so that only that path can qualify. A wrong gate polarity, or a missing path, therefore shows as an absent pulse. A retrigger by a falling `arm_an` in the middle of a pulse separates reload behaviour from plain extension or from ignoring the trigger. A change of `len_cycles` during a pulse shows whether the length is latched at the trigger. Gate-blocked edge trains, a zero length, a clear that falls in the same cycle as a trigger, and a clear that rises in the same cycle as one each test one qualification rule. Held input levels across reset release show whether the edge registers start from a clean state.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    localparam int DEF_CNT_W = 16;

    // Sampled levels of the three control inputs.
    typedef struct packed {
        logic arm_an;
        logic arm_b;
        logic kill_n;
    } ctl_pins_t;

    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_B_RISE   = 2'd1,
        SRC_A_FALL   = 2'd2,
        SRC_CLR_RISE = 2'd3
    } trig_src_e;

    typedef struct packed {
        logic      fire;
        trig_src_e src;
    } trig_t;

    // Decide whether the current sample, compared with the previous one,
    // holds a qualifying trigger. Only one source is reported per cycle.
    function automatic trig_t classify(input ctl_pins_t cur, input ctl_pins_t prv);
        trig_t t;
        t.src = SRC_NONE;
        if (cur.kill_n) begin
            if (cur.arm_b && !prv.arm_b && !cur.arm_an)
                t.src = SRC_B_RISE;
            else if (!cur.arm_an && prv.arm_an && cur.arm_b)
                t.src = SRC_A_FALL;
            else if (!prv.kill_n && !cur.arm_an && cur.arm_b)
                t.src = SRC_CLR_RISE;
        end
        t.fire = (t.src != SRC_NONE);
        return t;
    endfunction

endpackage

// File: rtl/oneshot_edge.sv
module oneshot_edge
    import oneshot_pkg::*;
(
    input  logic      clk,
    input  ctl_pins_t pins,
    output trig_t     trig
);
    ctl_pins_t prev_q;

    // The register follows the inputs in every cycle, reset included, so the
    // first cycle after reset release sees no edge on steady levels.
    always_ff @(posedge clk) begin
        prev_q <= pins;
    end

    always_comb begin
        trig = classify(pins, prev_q);
    end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kill_n,
    input  trig_t            trig,
    input  logic [CNT_W-1:0] len_cycles,
    output logic             busy
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst)
            remain_q <= CNT_ZERO;
        else if (!kill_n)
            remain_q <= CNT_ZERO;
        else if (trig.fire)
            remain_q <= len_cycles;
        else if (remain_q != CNT_ZERO)
            remain_q <= remain_q - CNT_ONE;
    end

    assign busy = (remain_q != CNT_ZERO);
endmodule

// File: rtl/oneshot_out.sv
module oneshot_out (
    input  logic busy,
    input  logic kill_n,
    output logic pulse_q,
    output logic pulse_qn
);
    // The clear gates the output directly, so the pulse ends in the cycle
    // the clear falls rather than one edge later.
    always_comb begin
        pulse_q  = busy & kill_n;
        pulse_qn = ~pulse_q;
    end
endmodule

// File: rtl/oneshot_gen.sv
module oneshot_gen
    import oneshot_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_an,
    input  logic             arm_b,
    input  logic             kill_n,
    input  logic [CNT_W-1:0] len_cycles,
    output logic             pulse_q,
    output logic             pulse_qn
);
    ctl_pins_t pins;
    trig_t     trig;
    logic      busy;

    always_comb begin
        pins.arm_an = arm_an;
        pins.arm_b  = arm_b;
        pins.kill_n = kill_n;
    end

    oneshot_edge u_edge (
        .clk  (clk),
        .pins (pins),
        .trig (trig)
    );

    oneshot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .kill_n     (kill_n),
        .trig       (trig),
        .len_cycles (len_cycles),
        .busy       (busy)
    );

    oneshot_out u_out (
        .busy     (busy),
        .kill_n   (kill_n),
        .pulse_q  (pulse_q),
        .pulse_qn (pulse_qn)
    );
endmodule

// File: rtl/oneshot_gen_chk.sv
module oneshot_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             arm_an,
    input logic             arm_b,
    input logic             kill_n,
    input logic [CNT_W-1:0] len_cycles,
    input logic             pulse_q,
    input logic             pulse_qn
);
    p_b_rise_start_r1: assert property (@(posedge clk) disable iff (rst)
        (arm_b && !$past(arm_b) && !arm_an && kill_n && len_cycles != '0)
        |=> (pulse_q || !kill_n));

    p_a_fall_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!arm_an && $past(arm_an) && arm_b && kill_n && len_cycles != '0)
        |=> (pulse_q || !kill_n));

    p_clr_rise_start_r3: assert property (@(posedge clk) disable iff (rst)
        (kill_n && !$past(kill_n) && !arm_an && arm_b && len_cycles != '0)
        |=> (pulse_q || !kill_n));

    p_clr_cancels_r4: assert property (@(posedge clk) disable iff (rst)
        !kill_n |=> !pulse_q);

    p_a_high_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (arm_an && $past(arm_an) && !pulse_q) |=> !pulse_q);

    p_zero_len_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (len_cycles == '0 && !pulse_q) |=> !pulse_q);

    p_reset_low_r10: assert property (@(posedge clk)
        rst |=> !pulse_q);
endmodule

bind oneshot_gen oneshot_gen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/oneshot_gen_test.sv
module oneshot_gen_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             arm_an = 1'b1;
    logic             arm_b = 1'b0;
    logic             kill_n = 1'b1;
    logic [CNT_W-1:0] len_cycles = '0;
    logic             pulse_q;
    logic             pulse_qn;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    always #2 clk = ~clk;

    oneshot_gen #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .arm_an(arm_an), .arm_b(arm_b),
        .kill_n(kill_n), .len_cycles(len_cycles),
        .pulse_q(pulse_q), .pulse_qn(pulse_qn)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts samples with pulse_q high, starting one cycle after the call.
    task automatic run_len(output int len);
        len = 0;
        tick(1);
        while (pulse_q === 1'b1 && len < 1000) begin
            chk("R9 complement", int'(pulse_qn), 0);
            len++;
            tick(1);
        end
    endtask

    task automatic go_idle();
        arm_an = 1'b1;
        arm_b  = 1'b0;
        tick(1);
        kill_n = 1'b1;
        tick(1);
        for (int i = 0; i < 200 && pulse_q === 1'b1; i++) tick(1);
    endtask

    task automatic t_reset();
        int len;
        tick(3);
        chk("R10 reset q", int'(pulse_q), 0);
        chk("R9 reset qn", int'(pulse_qn), 1);
        // Levels that would qualify if treated as edges, held across release.
        arm_an = 1'b0;
        arm_b  = 1'b1;
        len_cycles = 16'd5;
        tick(2);
        rst = 1'b0;
        run_len(len);
        chk("R10 no trigger at release", len, 0);
        go_idle();
    endtask

    task automatic t_b_rise();
        int len;
        len_cycles = 16'd5;
        arm_an = 1'b0;
        tick(1);
        arm_b = 1'b1;
        run_len(len);
        chk("R1 B rise width", len, 5);
        go_idle();
    endtask

    task automatic t_a_fall();
        int len;
        len_cycles = 16'd3;
        arm_b = 1'b1;
        tick(1);
        arm_an = 1'b0;
        run_len(len);
        chk("R2 A fall width", len, 3);
        go_idle();
    endtask

    task automatic t_clr_rise();
        int len;
        len_cycles = 16'd4;
        kill_n = 1'b0;
        tick(1);
        arm_an = 1'b0;
        tick(1);
        arm_b = 1'b1;
        tick(1);
        chk("R4 held low before release", int'(pulse_q), 0);
        kill_n = 1'b1;
        run_len(len);
        chk("R3 clear release width", len, 4);
        go_idle();
    endtask

    task automatic t_clear_cut();
        int len;
        len_cycles = 16'd10;
        arm_an = 1'b0;
        tick(1);
        arm_b = 1'b1;
        tick(3);
        chk("R1 pulse running", int'(pulse_q), 1);
        kill_n = 1'b0;
        #1;
        chk("R4 immediate low", int'(pulse_q), 0);
        chk("R9 qn during clear", int'(pulse_qn), 1);
        tick(1);
        arm_b = 1'b0;
        tick(1);
        arm_b = 1'b1;
        tick(3);
        chk("R4 B rise ignored while clear", int'(pulse_q), 0);
        arm_an = 1'b1;
        tick(1);
        kill_n = 1'b1;
        run_len(len);
        chk("R4 pulse not resumed", len, 0);
        go_idle();
    endtask

    task automatic t_retrigger();
        int len;
        len_cycles = 16'd6;
        arm_an = 1'b0;
        tick(1);
        arm_b = 1'b1;
        tick(2);
        arm_an = 1'b1;
        tick(2);
        arm_an = 1'b0;
        run_len(len);
        chk("R5 retrigger total", len + 4, 10);
        go_idle();
    endtask

    task automatic t_blocked();
        int hi = 0;
        len_cycles = 16'd4;
        for (int i = 0; i < 4; i++) begin
            arm_b = ~arm_b;
            tick(1);
            hi += int'(pulse_q);
        end
        chk("R6 B edges with A high", hi, 0);
        arm_b = 1'b0;
        hi = 0;
        for (int i = 0; i < 4; i++) begin
            arm_an = ~arm_an;
            tick(1);
            hi += int'(pulse_q);
        end
        tick(1);
        hi += int'(pulse_q);
        chk("R6 A edges with B low", hi, 0);
        go_idle();
    endtask

    task automatic t_zero_len();
        int len;
        len_cycles = 16'd0;
        arm_an = 1'b0;
        tick(1);
        arm_b = 1'b1;
        run_len(len);
        chk("R8 zero length", len, 0);
        go_idle();
    endtask

    task automatic t_len_latched();
        int len;
        len_cycles = 16'd4;
        arm_an = 1'b0;
        tick(1);
        arm_b = 1'b1;
        tick(1);
        len_cycles = 16'd9;
        run_len(len);
        chk("R7 length latched at trigger", len + 1, 4);
        go_idle();
    endtask

    task automatic t_same_cycle();
        int len;
        len_cycles = 16'd3;
        kill_n = 1'b0;
        arm_an = 1'b0;
        tick(1);
        kill_n = 1'b1;
        arm_b  = 1'b1;
        run_len(len);
        chk("R11 single pulse", len, 3);
        go_idle();
        arm_an = 1'b0;
        tick(1);
        kill_n = 1'b0;
        arm_b  = 1'b1;
        tick(1);
        kill_n = 1'b1;
        arm_an = 1'b1;
        run_len(len);
        chk("R4 trigger as clear falls ignored", len, 0);
        go_idle();
    endtask

    task automatic t_reset_mid();
        len_cycles = 16'd20;
        arm_an = 1'b0;
        tick(1);
        arm_b = 1'b1;
        tick(3);
        rst = 1'b1;
        tick(1);
        chk("R10 reset ends pulse", int'(pulse_q), 0);
        rst = 1'b0;
        tick(2);
        chk("R10 stays low after reset", int'(pulse_q), 0);
        go_idle();
    endtask

    initial begin
        t_reset();
        t_b_rise();
        t_a_fall();
        t_clr_rise();
        t_clear_cut();
        t_retrigger();
        t_blocked();
        t_zero_len();
        t_len_latched();
        t_same_cycle();
        t_reset_mid();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule